// File: doc/BRIEF.md
# Segment Selector Update Unit

This block keeps the six 16-bit segment selectors of a segmented processor (code, data, extra, stack and two additional data segments) and decides, for each retiring operation, whether that operation may write them and what it writes. It handles four groups of operations. The first is the selector move and the stack pop. The second is the pointer load, which writes a selector and a 32-bit offset together. The third is far jump, far call and far return, which are the only operations that may change the code selector. Any other instruction counts only as a retirement.

For each operation strobe the unit presents its write-back values in the same cycle. These are the general-register offset of a pointer load, the new instruction pointer of a far transfer, and the code-selector/instruction-pointer pair that a far call must push. It also raises an illegal-operation flag. The selector registers update on the following clock edge. The unit also keeps a one-instruction interrupt shadow. The shadow is raised when the stack selector is loaded alone, so that the next instruction can load the stack pointer without an interrupt in between. Descriptor lookup, privilege checks and real memory or stack traffic are done by neighbouring logic.

Top module: `seg_update_unit`

## Requirements
- R1: While `rst` is high and after it falls, the selector outputs are zero, except `seg_cs`, which equals parameter `CS_RESET` (default 16'hF000), and `irq_inhibit` is 0.
- R2: A legal move (`op_code`=1) or pop (`op_code`=2) writes `op_data[15:0]` into the selector picked by `op_dst` (0 extra, 1 code, 2 stack, 3 data, 4 first additional, 5 second additional) on the next clock edge. The other selectors keep their values.
- R3: A move or pop whose `op_dst` is 1 (code) raises `illegal` in the same cycle and changes no selector.
- R4: A move with `op_src_seg`=1 (source is itself a selector) raises `illegal` and changes no selector.
- R5: An `op_dst` of 6 or 7 on a move, pop or pointer load, or `op_code`=7, raises `illegal` and changes no selector.
- R6: A legal pointer load (`op_code`=3) writes `op_data[47:32]` into the `op_dst` selector on the next edge. In the same cycle it drives `gpr_we`=1, `gpr_idx`=`op_gpr` and `gpr_val`=`op_data[31:0]`.
- R7: A pointer load with `op_src_mem`=0 (register source), or with `op_dst`=1, raises `illegal` and writes nothing.
- R8: A far jump (`op_code`=4) drives `eip_we`=1 and `eip_val`=`op_data[31:0]` in the same cycle, and loads `seg_cs` with `op_data[47:32]` on the next edge.
- R9: A far call (`op_code`=5) drives `push_we`=1 with `push_val`={current `seg_cs`, `cur_eip`} in the same cycle, then loads the code selector and instruction pointer as in R8.
- R10: A far return (`op_code`=6) restores `seg_cs` from `op_data[47:32]` and the instruction pointer from `op_data[31:0]`, so that it reverses the matching far call.
- R11: After a legal move or pop into the stack selector retires, `irq_inhibit` is 1. It falls when the next strobed operation retires, unless that operation is again such a load. A repeated load never holds the shadow for more than one following instruction.
- R12: A pointer load into the stack selector leaves `irq_inhibit` at 0 after it retires.
- R13: With `op_valid` low, or when `illegal` is high, `gpr_we`, `eip_we` and `push_we` stay 0 and no selector changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe of a retiring operation |
| op_code | input | 3 | Operation kind (0 other, 1 move, 2 pop, 3 pointer load, 4 far jump, 5 far call, 6 far return) |
| op_dst | input | 3 | Target selector index |
| op_src_seg | input | 1 | Move source is a selector register |
| op_src_mem | input | 1 | Pointer-load source is a memory operand |
| op_gpr | input | 3 | General register receiving a pointer offset |
| op_data | input | 48 | Selector in [15:0] for move/pop; far pointer {selector, offset} otherwise |
| cur_eip | input | 32 | Current instruction pointer for a far call |
| seg_es | output | 16 | Extra selector |
| seg_cs | output | 16 | Code selector |
| seg_ss | output | 16 | Stack selector |
| seg_ds | output | 16 | Data selector |
| seg_fs | output | 16 | First additional selector |
| seg_gs | output | 16 | Second additional selector |
| gpr_we | output | 1 | Offset write-back strobe |
| gpr_idx | output | 3 | Offset write-back register |
| gpr_val | output | 32 | Offset write-back value |
| eip_we | output | 1 | Instruction pointer write strobe |
| eip_val | output | 32 | New instruction pointer |
| push_we | output | 1 | Far call push strobe |
| push_val | output | 48 | {code selector, instruction pointer} to push |
| illegal | output | 1 | Operation rejected |
| irq_inhibit | output | 1 | Interrupt shadow |

## Verification
The selector write rules are tried with each operation group against each kind of target. Legal moves and pops into data selectors show that only the addressed register changes. Moves and pops aimed at the code selector, selector-to-selector moves, out-of-range indices and the reserved code separate rejection from a silent write. Pointer loads with memory and register sources, and with a code target, show the offset path and its rejection. A jump, call and return sequence shows that the pushed pair matches what the return restores. Stack loads by move, pop, back-to-back moves and pointer load, each followed by an ordinary instruction, tell the one-instruction shadow apart from a stuck or missing one.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int SEL_W  = 16;
    localparam int OFF_W  = 32;
    localparam int PTR_W  = SEL_W + OFF_W;
    localparam int NSEG   = 6;
    localparam int SIDX_W = 3;
    localparam int GPR_W  = 3;

    typedef enum logic [2:0] {
        OP_OTHER = 3'd0,
        OP_MOVS  = 3'd1,
        OP_POPS  = 3'd2,
        OP_LDPTR = 3'd3,
        OP_JMPF  = 3'd4,
        OP_CALLF = 3'd5,
        OP_RETF  = 3'd6,
        OP_RSVD  = 3'd7
    } seg_op_e;

    typedef logic [SIDX_W-1:0] sidx_t;

    localparam sidx_t SR_ES = 3'd0;
    localparam sidx_t SR_CS = 3'd1;
    localparam sidx_t SR_SS = 3'd2;
    localparam sidx_t SR_DS = 3'd3;
    localparam sidx_t SR_FS = 3'd4;
    localparam sidx_t SR_GS = 3'd5;

    typedef struct packed {
        logic              illegal;
        logic              seg_we;
        sidx_t             seg_idx;
        logic [SEL_W-1:0]  seg_val;
        logic              eip_we;
        logic [OFF_W-1:0]  eip_val;
        logic              gpr_we;
        logic [GPR_W-1:0]  gpr_idx;
        logic [OFF_W-1:0]  gpr_val;
        logic              push_we;
        logic [PTR_W-1:0]  push_val;
        logic              shadow_set;
    } seg_ctl_t;

    function automatic logic seg_in_range(input sidx_t idx);
        return (int'(idx) < NSEG);
    endfunction

endpackage

// File: rtl/seg_decode.sv
module seg_decode
    import seg_pkg::*;
(
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  sidx_t             op_dst,
    input  logic              op_src_seg,
    input  logic              op_src_mem,
    input  logic [GPR_W-1:0]  op_gpr,
    input  logic [PTR_W-1:0]  op_data,
    input  logic [OFF_W-1:0]  cur_eip,
    input  logic [SEL_W-1:0]  cur_cs,
    output seg_ctl_t          ctl
);
    logic [SEL_W-1:0] sel_lo;
    logic [SEL_W-1:0] ptr_sel;
    logic [OFF_W-1:0] ptr_off;
    logic             dst_bad;

    assign sel_lo  = op_data[SEL_W-1:0];
    assign ptr_sel = op_data[PTR_W-1:OFF_W];
    assign ptr_off = op_data[OFF_W-1:0];
    assign dst_bad = !seg_in_range(op_dst) || (op_dst == SR_CS);

    always_comb begin
        ctl = '0;
        case (seg_op_e'(op_code))
            OP_MOVS, OP_POPS: begin
                if (dst_bad || ((seg_op_e'(op_code) == OP_MOVS) && op_src_seg)) begin
                    ctl.illegal = 1'b1;
                end else begin
                    ctl.seg_we     = 1'b1;
                    ctl.seg_idx    = op_dst;
                    ctl.seg_val    = sel_lo;
                    ctl.shadow_set = (op_dst == SR_SS);
                end
            end
            OP_LDPTR: begin
                if (dst_bad || !op_src_mem) begin
                    ctl.illegal = 1'b1;
                end else begin
                    ctl.seg_we  = 1'b1;
                    ctl.seg_idx = op_dst;
                    ctl.seg_val = ptr_sel;
                    ctl.gpr_we  = 1'b1;
                    ctl.gpr_idx = op_gpr;
                    ctl.gpr_val = ptr_off;
                end
            end
            OP_JMPF, OP_CALLF, OP_RETF: begin
                ctl.seg_we  = 1'b1;
                ctl.seg_idx = SR_CS;
                ctl.seg_val = ptr_sel;
                ctl.eip_we  = 1'b1;
                ctl.eip_val = ptr_off;
                if (seg_op_e'(op_code) == OP_CALLF) begin
                    ctl.push_we  = 1'b1;
                    ctl.push_val = {cur_cs, cur_eip};
                end
            end
            OP_OTHER: ctl = '0;
            default:  ctl.illegal = 1'b1;
        endcase
        if (!op_valid) begin
            ctl = '0;
        end
    end

endmodule

// File: rtl/seg_bank.sv
module seg_bank
    import seg_pkg::*;
#(
    parameter logic [SEL_W-1:0] CS_RESET = 16'hF000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  sidx_t                       wr_idx,
    input  logic [SEL_W-1:0]            wr_val,
    output logic [NSEG-1:0][SEL_W-1:0]  sel_q
);
    for (genvar g = 0; g < NSEG; g++) begin : g_sel
        localparam logic [SEL_W-1:0] RST_VAL = (g == int'(SR_CS)) ? CS_RESET : '0;
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[g] <= RST_VAL;
            end else if (wr_en && (int'(wr_idx) == g)) begin
                sel_q[g] <= wr_val;
            end
        end
    end

    // R13
    idle_bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(sel_q));

endmodule

// File: rtl/seg_irq_shadow.sv
module seg_irq_shadow (
    input  logic clk,
    input  logic rst,
    input  logic retire,
    input  logic set_req,
    output logic inhibit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            inhibit <= 1'b0;
        end else if (retire) begin
            inhibit <= set_req;
        end
    end

    // R11
    shadow_one_instr_chk: assert property (@(posedge clk) disable iff (rst)
        (inhibit && retire && !set_req) |=> !inhibit);

    // R11
    shadow_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (retire && set_req) |=> inhibit);

endmodule

// File: rtl/seg_update_unit.sv
module seg_update_unit
    import seg_pkg::*;
#(
    parameter logic [15:0] CS_RESET = 16'hF000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [2:0]   op_code,
    input  logic [2:0]   op_dst,
    input  logic         op_src_seg,
    input  logic         op_src_mem,
    input  logic [2:0]   op_gpr,
    input  logic [47:0]  op_data,
    input  logic [31:0]  cur_eip,
    output logic [15:0]  seg_es,
    output logic [15:0]  seg_cs,
    output logic [15:0]  seg_ss,
    output logic [15:0]  seg_ds,
    output logic [15:0]  seg_fs,
    output logic [15:0]  seg_gs,
    output logic         gpr_we,
    output logic [2:0]   gpr_idx,
    output logic [31:0]  gpr_val,
    output logic         eip_we,
    output logic [31:0]  eip_val,
    output logic         push_we,
    output logic [47:0]  push_val,
    output logic         illegal,
    output logic         irq_inhibit
);
    seg_ctl_t                      ctl;
    logic [NSEG-1:0][SEL_W-1:0]    sel_q;

    seg_decode u_dec (
        .op_valid   (op_valid),
        .op_code    (op_code),
        .op_dst     (op_dst),
        .op_src_seg (op_src_seg),
        .op_src_mem (op_src_mem),
        .op_gpr     (op_gpr),
        .op_data    (op_data),
        .cur_eip    (cur_eip),
        .cur_cs     (sel_q[SR_CS]),
        .ctl        (ctl)
    );

    seg_bank #(.CS_RESET(CS_RESET)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ctl.seg_we),
        .wr_idx (ctl.seg_idx),
        .wr_val (ctl.seg_val),
        .sel_q  (sel_q)
    );

    seg_irq_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .retire  (op_valid),
        .set_req (ctl.shadow_set),
        .inhibit (irq_inhibit)
    );

    assign seg_es   = sel_q[SR_ES];
    assign seg_cs   = sel_q[SR_CS];
    assign seg_ss   = sel_q[SR_SS];
    assign seg_ds   = sel_q[SR_DS];
    assign seg_fs   = sel_q[SR_FS];
    assign seg_gs   = sel_q[SR_GS];
    assign gpr_we   = ctl.gpr_we;
    assign gpr_idx  = ctl.gpr_idx;
    assign gpr_val  = ctl.gpr_val;
    assign eip_we   = ctl.eip_we;
    assign eip_val  = ctl.eip_val;
    assign push_we  = ctl.push_we;
    assign push_val = ctl.push_val;
    assign illegal  = ctl.illegal;

    // R3
    cs_move_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 3'd1 || op_code == 3'd2) && op_dst == 3'd1) |-> illegal);

    // R4
    illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |=> $stable(sel_q));

    // R13
    illegal_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !(gpr_we || eip_we || push_we));

    // R9
    call_push_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd5) |-> (push_we && push_val[47:32] == seg_cs));

    // R12
    ptr_ss_no_shadow_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd3) |=> !irq_inhibit);

endmodule

// File: tb/test_seg_update_unit.sv
`timescale 1ns/1ps
module test_seg_update_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [2:0]  op_dst = '0;
    logic        op_src_seg = 1'b0;
    logic        op_src_mem = 1'b0;
    logic [2:0]  op_gpr = '0;
    logic [47:0] op_data = '0;
    logic [31:0] cur_eip = '0;
    logic [15:0] seg_es, seg_cs, seg_ss, seg_ds, seg_fs, seg_gs;
    logic        gpr_we, eip_we, push_we, illegal, irq_inhibit;
    logic [2:0]  gpr_idx;
    logic [31:0] gpr_val, eip_val;
    logic [47:0] push_val;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    seg_update_unit i_seg_update_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_dst(op_dst),
        .op_src_seg(op_src_seg), .op_src_mem(op_src_mem), .op_gpr(op_gpr),
        .op_data(op_data), .cur_eip(cur_eip),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .seg_fs(seg_fs), .seg_gs(seg_gs), .gpr_we(gpr_we), .gpr_idx(gpr_idx),
        .gpr_val(gpr_val), .eip_we(eip_we), .eip_val(eip_val), .push_we(push_we),
        .push_val(push_val), .illegal(illegal), .irq_inhibit(irq_inhibit)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  dst;
        logic        sseg;
        logic        smem;
        logic [2:0]  gpr;
        logic [47:0] data;
        logic [31:0] eip;
        logic        ill;
        logic        inh;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 3'd3, 1'b0, 1'b0, 3'd0, 48'h1111,             32'h0,    1'b0, 1'b0, 4'd2},  // R2 move DS
        '{3'd2, 3'd0, 1'b0, 1'b0, 3'd0, 48'h2222,             32'h0,    1'b0, 1'b0, 4'd2},  // R2 pop ES
        '{3'd1, 3'd1, 1'b0, 1'b0, 3'd0, 48'hAAAA,             32'h0,    1'b1, 1'b0, 4'd3},  // R3 move CS
        '{3'd2, 3'd1, 1'b0, 1'b0, 3'd0, 48'hBBBB,             32'h0,    1'b1, 1'b0, 4'd3},  // R3 pop CS
        '{3'd1, 3'd4, 1'b1, 1'b0, 3'd0, 48'hCCCC,             32'h0,    1'b1, 1'b0, 4'd4},  // R4 seg to seg
        '{3'd1, 3'd6, 1'b0, 1'b0, 3'd0, 48'hDDDD,             32'h0,    1'b1, 1'b0, 4'd5},  // R5 bad index
        '{3'd7, 3'd3, 1'b0, 1'b1, 3'd0, 48'hEEEE,             32'h0,    1'b1, 1'b0, 4'd5},  // R5 reserved op
        '{3'd3, 3'd5, 1'b0, 1'b1, 3'd6, 48'h3333_DEADBEEF,    32'h0,    1'b0, 1'b0, 4'd6},  // R6 ptr GS
        '{3'd3, 3'd3, 1'b0, 1'b0, 3'd2, 48'h4242_00000042,    32'h0,    1'b1, 1'b0, 4'd7},  // R7 reg source
        '{3'd3, 3'd1, 1'b0, 1'b1, 3'd2, 48'h4343_00000043,    32'h0,    1'b1, 1'b0, 4'd7},  // R7 CS target
        '{3'd4, 3'd0, 1'b0, 1'b0, 3'd0, 48'h4444_00001000,    32'h0,    1'b0, 1'b0, 4'd8},  // R8 far jump
        '{3'd5, 3'd0, 1'b0, 1'b0, 3'd0, 48'h5555_00002000,    32'h1234, 1'b0, 1'b0, 4'd9},  // R9 far call
        '{3'd6, 3'd0, 1'b0, 1'b0, 3'd0, 48'h4444_00001234,    32'h0,    1'b0, 1'b0, 4'd10}, // R10 far return
        '{3'd2, 3'd2, 1'b0, 1'b0, 3'd0, 48'h6666,             32'h0,    1'b0, 1'b1, 4'd11}, // R11 pop SS
        '{3'd0, 3'd0, 1'b0, 1'b0, 3'd0, 48'h0,                32'h0,    1'b0, 1'b0, 4'd11}, // R11 next clears
        '{3'd1, 3'd2, 1'b0, 1'b0, 3'd0, 48'h7777,             32'h0,    1'b0, 1'b1, 4'd11}, // R11 move SS
        '{3'd1, 3'd2, 1'b0, 1'b0, 3'd0, 48'h7778,             32'h0,    1'b0, 1'b1, 4'd11}, // R11 again
        '{3'd0, 3'd0, 1'b0, 1'b0, 3'd0, 48'h0,                32'h0,    1'b0, 1'b0, 4'd11}, // R11 one only
        '{3'd1, 3'd2, 1'b0, 1'b0, 3'd0, 48'h8888,             32'h0,    1'b0, 1'b1, 4'd11}, // R11
        '{3'd3, 3'd2, 1'b0, 1'b1, 3'd4, 48'h9999_00000055,    32'h0,    1'b0, 1'b0, 4'd12}, // R12 ptr SS
        '{3'd3, 3'd4, 1'b0, 1'b1, 3'd1, 48'hABCD_00000077,    32'h0,    1'b0, 1'b0, 4'd6}   // R6 ptr FS
    };

    logic [15:0] m_sel [6];

    function automatic logic [15:0] dut_sel(input int i);
        case (i)
            0: return seg_es;
            1: return seg_cs;
            2: return seg_ss;
            3: return seg_ds;
            4: return seg_fs;
            default: return seg_gs;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all_sel(input string tag);
        for (int i = 0; i < 6; i++) check(tag, 64'(dut_sel(i)), 64'(m_sel[i]));
    endtask

    task automatic model_reset();
        for (int i = 0; i < 6; i++) m_sel[i] = (i == 1) ? 16'hF000 : 16'h0;
    endtask

    task automatic run_vec(input vec_t v);
        string tag;
        logic  leg;
        tag = $sformatf("R%0d", v.req);
        leg = !v.ill;
        @(negedge clk);
        op_code = v.op; op_dst = v.dst; op_src_seg = v.sseg; op_src_mem = v.smem;
        op_gpr = v.gpr; op_data = v.data; cur_eip = v.eip; op_valid = 1'b1;
        #2;
        check({tag, " illegal"}, 64'(illegal), 64'(v.ill));
        check({tag, " gpr_we"},  64'(gpr_we),  64'(leg && v.op == 3'd3));
        if (leg && v.op == 3'd3) begin
            check({tag, " gpr_idx"}, 64'(gpr_idx), 64'(v.gpr));
            check({tag, " gpr_val"}, 64'(gpr_val), 64'(v.data[31:0]));
        end
        check({tag, " eip_we"}, 64'(eip_we), 64'(leg && v.op >= 3'd4 && v.op <= 3'd6));
        if (leg && v.op >= 3'd4 && v.op <= 3'd6)
            check({tag, " eip_val"}, 64'(eip_val), 64'(v.data[31:0]));
        check({tag, " push_we"}, 64'(push_we), 64'(leg && v.op == 3'd5));
        if (leg && v.op == 3'd5)
            check({tag, " push_val"}, 64'(push_val), 64'({m_sel[1], v.eip}));
        if (leg) begin
            if (v.op == 3'd1 || v.op == 3'd2) m_sel[v.dst] = v.data[15:0];
            else if (v.op == 3'd3)            m_sel[v.dst] = v.data[47:32];
            else if (v.op >= 3'd4 && v.op <= 3'd6) m_sel[1] = v.data[47:32];
        end
        @(negedge clk);
        op_valid = 1'b0;
        check_all_sel({tag, " selectors"});
        check({tag, " irq_inhibit"}, 64'(irq_inhibit), 64'(v.inh));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset values while held
        check_all_sel("R1 in reset");
        check("R1 inhibit", 64'(irq_inhibit), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        check_all_sel("R1 after release");

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R13 strobe low: a far call pattern must not act
        @(negedge clk);
        op_code = 3'd5; op_data = 48'h7E7E_0000AAAA; cur_eip = 32'h99; op_valid = 1'b0;
        #2;
        check("R13 push_we idle", 64'(push_we), 64'(0));
        check("R13 eip_we idle",  64'(eip_we),  64'(0));
        @(negedge clk);
        check_all_sel("R13 idle hold");

        // R11 shadow then reset clears it
        run_vec('{3'd2, 3'd2, 1'b0, 1'b0, 3'd0, 48'h1357, 32'h0, 1'b0, 1'b1, 4'd11});
        rst = 1'b1;
        @(negedge clk);
        model_reset();
        check("R1 reset clears inhibit", 64'(irq_inhibit), 64'(0));
        check_all_sel("R1 reset mid-run");
        rst = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule